// File: doc/BRIEF.md
# FSK Caller-ID Burst Sequencer

This block builds the serial bit stream of one caller-ID burst and moves forward one bit on each baud tick. A burst has four parts in a fixed order. First comes a seizure run of alternating bits. Next come a mark run of ones and then a flag run of ones. Last come the message bytes, which are read from a small message store that several line channels share. Each byte goes out as a ten-bit frame. Tone synthesis happens downstream: that stage takes the bit, the bit-valid strobe and the channel number, and it picks the pair of tones. The block does not produce tones itself.

A host fills the store one 16-bit word at a time through a plain write port and can read any word back through a read port. The host also sets the three segment lengths, the byte count, the channel and two control bits. The enable bit gates everything. The hold bit keeps the line at mark once the bytes are sent, so that the host can refill the store and relaunch only the byte phase without sending the preamble again. A long message can go out this way in pieces.

Top module: `fsk_cid_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `busy`, `holding` and `bit_vld` are 0 and `chan_out` is 0. Every store word reads back as 0.
- R2: A `start` pulse launches a burst only when `fsk_on` is 1 and the block is idle. It also latches `chan_sel` into `chan_out`, which then stays fixed for the whole burst. A `start` while `fsk_on` is 0 has no effect.
- R3: The seizure part is 2·`seize_len` bits long. It alternates between 0 and 1 and begins with 0.
- R4: The mark part is `mark_len` ones and the flag part is `flag_len` ones. Any part whose length is 0 is skipped.
- R5: Message byte k comes from word k/2 of the store. Bits [15:8] are used when k is even and bits [7:0] when k is odd. Each byte goes out as a 0, then its eight bits with bit 0 first, then a 1.
- R6: The block sends min(`data_len`, 64) bytes. After the stop bit of the last byte, `busy` goes low in the same cycle that this bit appears, provided `mark_hold` is 0. A `data_len` of 0 skips the byte phase.
- R7: If `mark_hold` is 1 when the bytes end, `holding` rises and every tick sends a 1. Clearing `mark_hold` ends the hold, and `busy` and `holding` fall in the next cycle.
- R8: A `start` during hold restarts the byte phase at byte 0 and sends no preamble. In that cycle `start` takes priority over `tick`, so no bit is sent.
- R9: A store write takes effect only when the block is idle or holding. `rd_data` always shows the word at `rd_addr`, and a write appears on it in the cycle after the write.
- R10: Clearing `fsk_on` stops the burst from any part, including hold. `busy` is 0 in the next cycle and no bit is sent.
- R11: A tick that the block accepts while sending puts one bit on `bit_out`, with `bit_vld` high, in the next cycle. `bit_vld` is never high at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Baud tick; advances the stream by one bit |
| fsk_on | input | 1 | Global enable; clearing it stops any burst |
| start | input | 1 | Launch pulse (also restarts the byte phase during hold) |
| mark_hold | input | 1 | Keep sending ones after the bytes end |
| seize_len | input | 8 | Seizure setting; the part is twice this many bits |
| mark_len | input | 8 | Mark part length in bits |
| flag_len | input | 8 | Flag part length in bits |
| data_len | input | 7 | Bytes to send; values above 64 act as 64 |
| chan_sel | input | 3 | Channel that will carry the burst |
| wr_en | input | 1 | Store write strobe |
| wr_addr | input | 5 | Store write word address |
| wr_data | input | 16 | Store write word |
| rd_addr | input | 5 | Store read word address |
| rd_data | output | 16 | Store word at rd_addr |
| bit_out | output | 1 | Serial bit |
| bit_vld | output | 1 | High for one cycle when a new bit is on bit_out |
| chan_out | output | 3 | Channel latched at launch |
| busy | output | 1 | A burst or hold is in progress |
| holding | output | 1 | Mark-hold in progress |

## Verification
Two pairs of events can land in the same cycle, and the bench provokes both during mark-hold. In one, the host write and the restart pulse arrive together. The bench judges it by whether the restarted bytes already hold the new word. In the other, the restart pulse lands on a cycle where the baud tick is high, because ticks run every cycle. The bench expects no bit in that cycle and expects the next tick to send the start bit of byte 0. A behavioural model rebuilds the expected bit queue from its own copy of the store. It is compared with the outputs on every clock, including in the cycles right after a write was refused while sending.

// File: rtl/fsk_cid_pkg.sv
package fsk_cid_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SEIZE = 3'd1,
        PH_MARK  = 3'd2,
        PH_FLAG  = 3'd3,
        PH_DATA  = 3'd4,
        PH_HOLD  = 3'd5
    } phase_e;

endpackage

// File: rtl/fsk_msg_ram.sv
module fsk_msg_ram #(
    parameter int WORDS  = 32,
    parameter int WORD_W = 16,
    localparam int ADDR_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [WORD_W-1:0] rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [WORD_W-1:0] rdata_b
);

    logic [WORD_W-1:0] mem_q [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[w] <= '0;
            end else if (we && (waddr == ADDR_W'(w))) begin
                mem_q[w] <= wdata;
            end
        end
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];

endmodule

// File: rtl/fsk_frame_bit.sv
module fsk_frame_bit #(
    parameter int BYTE_W = 8,
    localparam int BP_W = $clog2(BYTE_W + 2)
) (
    input  logic [2*BYTE_W-1:0] word,
    input  logic                lower,
    input  logic [BP_W-1:0]     pos,
    output logic                bit_o
);

    logic [BYTE_W-1:0] sel_byte;

    always_comb begin
        sel_byte = lower ? word[BYTE_W-1:0] : word[2*BYTE_W-1:BYTE_W];
        // position 0 is the start bit, BYTE_W+1 the stop bit
        bit_o = (pos != '0);
        for (int i = 0; i < BYTE_W; i++) begin
            if (pos == BP_W'(i + 1)) begin
                bit_o = sel_byte[i];
            end
        end
    end

endmodule

// File: rtl/fsk_cid_seq.sv
module fsk_cid_seq
    import fsk_cid_pkg::*;
#(
    parameter int WORDS  = 32,
    parameter int BYTE_W = 8,
    parameter int LEN_W  = 8,
    parameter int DLEN_W = 7,
    parameter int CHAN_W = 3,
    localparam int WORD_W = 2 * BYTE_W,
    localparam int ADDR_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              fsk_on,
    input  logic              start,
    input  logic              mark_hold,
    input  logic [LEN_W-1:0]  seize_len,
    input  logic [LEN_W-1:0]  mark_len,
    input  logic [LEN_W-1:0]  flag_len,
    input  logic [DLEN_W-1:0] data_len,
    input  logic [CHAN_W-1:0] chan_sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              bit_out,
    output logic              bit_vld,
    output logic [CHAN_W-1:0] chan_out,
    output logic              busy,
    output logic              holding
);

    localparam int MAX_BYTES = 2 * WORDS;
    localparam int IDX_W     = $clog2(MAX_BYTES);
    localparam int REM_W     = LEN_W + 1;
    localparam int BP_W      = $clog2(BYTE_W + 2);
    localparam int STOP_POS  = BYTE_W + 1;

    typedef struct packed {
        phase_e             phase;
        logic [REM_W-1:0]   rem;
        logic [IDX_W-1:0]   byte_idx;
        logic [BP_W-1:0]    bitpos;
        logic               bit_o;
        logic               vld;
        logic [CHAN_W-1:0]  chan;
    } seq_st_t;

    typedef struct packed {
        phase_e           ph;
        logic [REM_W-1:0] n;
    } entry_t;

    seq_st_t           s_d, s_q;
    logic              ram_we;
    logic [WORD_W-1:0] seq_word;
    logic              frame_bit;
    logic [REM_W-1:0]  dlen_eff;
    entry_t            ent;

    // Walk forward from a part, skipping those of zero length.
    function automatic entry_t enter(phase_e from, logic [LEN_W-1:0] sl,
                                     logic [LEN_W-1:0] ml, logic [LEN_W-1:0] fl,
                                     logic [REM_W-1:0] dl, logic hold_en);
        entry_t e;
        e.n = '0;
        if ((from <= PH_SEIZE) && (sl != '0)) begin
            e.ph = PH_SEIZE;
            e.n  = {sl, 1'b0};
        end else if ((from <= PH_MARK) && (ml != '0)) begin
            e.ph = PH_MARK;
            e.n  = {1'b0, ml};
        end else if ((from <= PH_FLAG) && (fl != '0)) begin
            e.ph = PH_FLAG;
            e.n  = {1'b0, fl};
        end else if ((from <= PH_DATA) && (dl != '0)) begin
            e.ph = PH_DATA;
            e.n  = dl;
        end else begin
            e.ph = hold_en ? PH_HOLD : PH_IDLE;
        end
        return e;
    endfunction

    assign dlen_eff = (int'(data_len) > MAX_BYTES) ? REM_W'(MAX_BYTES) : REM_W'(data_len);
    assign ram_we   = wr_en && ((s_q.phase == PH_IDLE) || (s_q.phase == PH_HOLD));

    fsk_msg_ram #(.WORDS(WORDS), .WORD_W(WORD_W)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ram_we),
        .waddr   (wr_addr),
        .wdata   (wr_data),
        .raddr_a (rd_addr),
        .rdata_a (rd_data),
        .raddr_b (s_q.byte_idx[IDX_W-1:1]),
        .rdata_b (seq_word)
    );

    fsk_frame_bit #(.BYTE_W(BYTE_W)) u_frame (
        .word  (seq_word),
        .lower (s_q.byte_idx[0]),
        .pos   (s_q.bitpos),
        .bit_o (frame_bit)
    );

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        ent     = '{ph: PH_IDLE, n: '0};
        if (!fsk_on) begin
            s_d.phase = PH_IDLE;
        end else begin
            unique case (s_q.phase)
                PH_IDLE: begin
                    if (start) begin
                        ent          = enter(PH_SEIZE, seize_len, mark_len, flag_len, dlen_eff, mark_hold);
                        s_d.phase    = ent.ph;
                        s_d.rem      = ent.n;
                        s_d.chan     = chan_sel;
                        s_d.byte_idx = '0;
                        s_d.bitpos   = '0;
                    end
                end
                PH_HOLD: begin
                    if (start) begin
                        ent          = enter(PH_DATA, seize_len, mark_len, flag_len, dlen_eff, mark_hold);
                        s_d.phase    = ent.ph;
                        s_d.rem      = ent.n;
                        s_d.byte_idx = '0;
                        s_d.bitpos   = '0;
                    end else if (!mark_hold) begin
                        s_d.phase = PH_IDLE;
                    end else if (tick) begin
                        s_d.vld   = 1'b1;
                        s_d.bit_o = 1'b1;
                    end
                end
                PH_SEIZE, PH_MARK, PH_FLAG: begin
                    if (tick) begin
                        s_d.vld   = 1'b1;
                        s_d.bit_o = (s_q.phase == PH_SEIZE) ? s_q.rem[0] : 1'b1;
                        s_d.rem   = s_q.rem - 1'b1;
                        if (s_q.rem == REM_W'(1)) begin
                            ent       = enter(phase_e'(s_q.phase + 3'd1), seize_len, mark_len,
                                              flag_len, dlen_eff, mark_hold);
                            s_d.phase = ent.ph;
                            s_d.rem   = ent.n;
                        end
                    end
                end
                PH_DATA: begin
                    if (tick) begin
                        s_d.vld   = 1'b1;
                        s_d.bit_o = frame_bit;
                        if (s_q.bitpos == BP_W'(STOP_POS)) begin
                            s_d.bitpos   = '0;
                            s_d.byte_idx = s_q.byte_idx + 1'b1;
                            s_d.rem      = s_q.rem - 1'b1;
                            if (s_q.rem == REM_W'(1)) begin
                                s_d.phase = mark_hold ? PH_HOLD : PH_IDLE;
                            end
                        end else begin
                            s_d.bitpos = s_q.bitpos + 1'b1;
                        end
                    end
                end
                default: s_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign bit_out  = s_q.bit_o;
    assign bit_vld  = s_q.vld;
    assign chan_out = s_q.chan;
    assign busy     = (s_q.phase != PH_IDLE);
    assign holding  = (s_q.phase == PH_HOLD);

endmodule

// File: rtl/fsk_cid_seq_chk.sv
module fsk_cid_seq_chk #(
    parameter int CHAN_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              fsk_on,
    input logic              bit_out,
    input logic              bit_vld,
    input logic [CHAN_W-1:0] chan_out,
    input logic              busy,
    input logic              holding
);

    assert_vld_after_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |-> $past(tick));

    assert_hold_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        holding |-> busy);

    assert_hold_sends_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && holding && $past(holding)) |-> bit_out);

    assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !fsk_on |=> (!busy && !bit_vld));

    assert_chan_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(chan_out));

endmodule

bind fsk_cid_seq fsk_cid_seq_chk #(.CHAN_W(CHAN_W)) u_chk (.*);

// File: tb/tb_fsk_cid_seq.sv
module tb_fsk_cid_seq;

    logic        clk = 1'b0;
    logic        rst_n, tick, fsk_on, start, mark_hold, wr_en;
    logic [7:0]  seize_len, mark_len, flag_len;
    logic [6:0]  data_len;
    logic [2:0]  chan_sel;
    logic [4:0]  wr_addr, rd_addr;
    logic [15:0] wr_data, rd_data;
    logic        bit_out, bit_vld, busy, holding;
    logic [2:0]  chan_out;

    fsk_cid_seq dut (.*);

    always #2 clk = ~clk;

    int    n_tests = 0, n_fail = 0, tick_mode = 0, tcnt = 0, cycles = 0;
    string cur_req = "R1";
    logic [15:0] mmem [32];
    int    q[$];
    logic  e_vld, e_bit, m_busy, m_hold;
    logic [2:0] m_chan;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push_data();
        int nb = (data_len > 64) ? 64 : int'(data_len);
        for (int k = 0; k < nb; k++) begin
            logic [15:0] w = mmem[k/2];
            logic [7:0]  b = (k % 2) ? w[7:0] : w[15:8];
            q.push_back(0);
            for (int i = 0; i < 8; i++) q.push_back(int'(b[i]));
            q.push_back(1);
        end
    endtask

    // behavioural reference, advanced on every clock
    always @(posedge clk) begin
        if (!rst_n) begin
            e_vld = 0; e_bit = 0; m_busy = 0; m_hold = 0; m_chan = 0; q.delete();
            for (int i = 0; i < 32; i++) mmem[i] = 16'h0;
        end else begin
            if (wr_en && (!m_busy || m_hold)) mmem[wr_addr] = wr_data;
            e_vld = 0;
            if (!fsk_on) begin
                m_busy = 0; m_hold = 0; q.delete();
            end else if (m_hold) begin
                if (start) begin
                    q.delete(); push_data(); m_hold = 0;
                    if (q.size() == 0) begin m_hold = mark_hold; m_busy = mark_hold; end
                end else if (!mark_hold) begin
                    m_busy = 0; m_hold = 0;
                end else if (tick) begin
                    e_vld = 1; e_bit = 1;
                end
            end else if (m_busy) begin
                if (tick) begin
                    e_vld = 1; e_bit = q.pop_front();
                    if (q.size() == 0) begin m_hold = mark_hold; m_busy = mark_hold; end
                end
            end else if (start) begin
                m_chan = chan_sel; q.delete();
                for (int i = 0; i < 2*int'(seize_len); i++) q.push_back(i % 2);
                for (int i = 0; i < int'(mark_len) + int'(flag_len); i++) q.push_back(1);
                push_data();
                m_busy = 1;
                if (q.size() == 0) begin m_hold = mark_hold; m_busy = mark_hold; end
            end
        end
    end

    // compare on every clock, away from the edge
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            chk(bit_vld == e_vld, {cur_req, " R11 bit_vld"}, bit_vld, e_vld);
            if (e_vld) chk(bit_out == e_bit, {cur_req, " bit_out"}, bit_out, e_bit);
            chk(busy == m_busy, {cur_req, " busy"}, busy, m_busy);
            chk(holding == m_hold, {cur_req, " R7 holding"}, holding, m_hold);
            chk(chan_out == m_chan, {cur_req, " R2 chan_out"}, chan_out, m_chan);
            chk(rd_data == mmem[rd_addr], {cur_req, " R9 rd_data"}, rd_data, mmem[rd_addr]);
        end
    end

    initial forever begin
        @(posedge clk); #1;
        tcnt++;
        tick = (tick_mode == 1) || (tick_mode == 2 && (tcnt % 3) == 0);
    end

    initial forever begin
        @(posedge clk);
        cycles++;
        if (cycles > 150000) begin
            chk(0, "watchdog", cycles, 150000);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        wr_en = 1; wr_addr = a; wr_data = d; step(1); wr_en = 0;
    endtask

    task automatic go();
        start = 1; step(1); start = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && busy; i++) step(1);
    endtask

    task automatic wait_hold();
        for (int i = 0; i < 5000 && !holding; i++) step(1);
    endtask

    task automatic cfg(input int s, input int m, input int f, input int d,
                       input int c, input bit h);
        seize_len = 8'(s); mark_len = 8'(m); flag_len = 8'(f);
        data_len = 7'(d); chan_sel = 3'(c); mark_hold = h;
    endtask

    initial begin
        rst_n = 0; fsk_on = 0; start = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
        rd_addr = 0; tick = 0;
        cfg(0, 0, 0, 0, 0, 0);
        step(3);
        // R1: outputs during reset
        chk(!busy && !holding && !bit_vld && chan_out == 0, "R1 reset", busy, 0);
        chk(rd_data == 16'h0, "R1 store cleared", rd_data, 0);
        rst_n = 1;
        step(1);
        chk(!busy && !bit_vld, "R1 after release", busy, 0);

        cur_req = "R9 load";
        fsk_on = 1;
        for (int w = 0; w < 32; w++) begin
            rd_addr = 5'(w);
            wr(5'(w), 16'(w * 16'h1357) ^ 16'hA5C3);
        end

        cur_req = "R3 R4 R5 R6";
        tick_mode = 1;
        cfg(3, 4, 2, 5, 5, 0);
        go(); wait_idle(); step(3);
        chk(!busy, "R6 busy low after bytes", busy, 0);

        cur_req = "R11 R3 sparse ticks";
        tick_mode = 2;
        cfg(1, 2, 1, 4, 2, 0);
        go(); wait_idle(); step(4);

        cur_req = "R2";
        fsk_on = 0; cfg(2, 2, 2, 2, 6, 0);
        go(); step(4);
        chk(!busy, "R2 start ignored while disabled", busy, 0);
        fsk_on = 1; step(1);

        cur_req = "R4 zero parts";
        tick_mode = 1;
        cfg(0, 0, 3, 2, 1, 0);
        go(); wait_idle(); step(2);

        cur_req = "R6 zero length";
        cfg(0, 0, 0, 0, 4, 0);
        go(); step(3);
        chk(!busy, "R6 empty burst", busy, 0);

        cur_req = "R9 blocked write";
        cfg(4, 2, 2, 3, 3, 0);
        go(); step(2);
        rd_addr = 5'd1;
        wr(5'd1, 16'hDEAD); step(2);
        chk(rd_data != 16'hDEAD, "R9 write while sending", rd_data, 0);
        wait_idle(); step(2);

        cur_req = "R7 hold";
        cfg(1, 1, 1, 3, 7, 1);
        go(); wait_hold(); step(6);
        rd_addr = 5'd0;
        wr(5'd0, 16'h00FF); step(1);
        chk(rd_data == 16'h00FF, "R9 write during hold", rd_data, 16'h00FF);

        cur_req = "R8 restart with write";
        wr_en = 1; wr_addr = 5'd1; wr_data = 16'h8001; start = 1;
        step(1);
        wr_en = 0; start = 0;
        chk(!holding && busy, "R8 restart leaves hold", holding, 0);
        wait_hold(); step(3);
        cur_req = "R7 release";
        mark_hold = 0; step(2);
        chk(!busy && !holding, "R7 hold released", busy, 0);

        cur_req = "R10 abort";
        cfg(20, 2, 2, 2, 2, 0);
        go(); step(10);
        fsk_on = 0; step(2);
        chk(!busy, "R10 abort in seizure", busy, 0);
        fsk_on = 1; step(1);
        cfg(0, 1, 0, 1, 5, 1);
        go(); wait_hold(); step(2);
        fsk_on = 0; step(2);
        chk(!busy && !holding, "R10 abort in hold", busy, 0);
        fsk_on = 1; mark_hold = 0; step(1);

        cur_req = "R6 clamp";
        cfg(0, 0, 1, 100, 6, 0);
        go(); wait_idle(); step(3);
        chk(!busy, "R6 clamped burst ends", busy, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule